// File: doc/BRIEF.md
# SDLC Frame Serializer

This block turns a stream of bytes into a bit-oriented synchronous link frame on a single serial line. Bytes arrive over a valid/ready handshake, the final byte of a frame marked by a last flag. The line advances by one bit for every cycle in which the bit strobe is high. The block wraps each frame in the pattern 01111110, inserts a zero after every run of five ones in the payload, and appends a 16-bit frame check. It can cut a frame short with a run of ones.

Between frames the line carries either repeated flags or steady ones, chosen by a static input. When a new frame is ready as a closing flag ends, that flag also opens the next frame. If the source stalls in the middle of a frame, or if an abort is requested, the frame is ended with an abort run rather than sent damaged. The source is responsible for discarding any remaining bytes of the aborted frame.

Top module: `sdlc_frame_tx`

## Requirements
- R1: While reset is held and just after it, `tx_bit` is 1 and `in_ready` is 0. The block starts in the idle state.
- R2: In idle with `idle_flags`=1 the line repeats the octet 0x7E, LSB first. With `idle_flags`=0 the line stays at 1.
- R3: A frame opens with one flag octet. Payload bytes then follow, each sent least significant bit first.
- R4: After five consecutive payload ones, which may be data, check or a mix, the next line bit is an inserted 0. Flag and abort bits are never stuffed.
- R5: The check field is the ones complement of a reflected CRC-CCITT register (polynomial 0x8408 in LSB-first form, preset 0xFFFF), sent low byte first. For the payload "123456789" the check bytes are 0x6E then 0x90. Running the same CRC over payload plus check leaves 0xF0B8.
- R6: Inserted zeros do not enter the CRC.
- R7: Each frame ends with a flag after its check field. If `in_valid` is high when that flag ends, the next frame's payload follows with no further flag.
- R8: `abort_req`, if high on a strobe during payload or check, makes the block send ABORT_ONES ones (at least 7) and then return to idle. In idle, opening-flag or closing-flag states, `abort_req` has no effect.
- R9: If `in_valid` is low when a new payload byte is due, the frame is aborted as in R8.
- R10: `in_ready` is high only in a strobe cycle at a payload byte boundary. A byte is taken when `in_valid` and `in_ready` are both high, and its bit 0 appears on `tx_bit` after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe; the line advances one bit per strobe |
| idle_flags | input | 1 | Idle fill: 1 = flags, 0 = ones |
| abort_req | input | 1 | Request to abort the frame in progress |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_last | input | 1 | Payload byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte on this clock edge |
| tx_bit | output | 1 | Serial line output |

## Verification
Every cycle, the assertions check the following. A stuffing decision forces a zero onto the line. The ones counter never passes its limit. A stuffed zero leaves the CRC untouched. Abort bits are ones. An accepted byte's bit 0 reaches the line next.

Only the bench scenarios can show end-to-end behaviour. It decodes the line as a receiver would, removing stuffed bits and finding flags. This is how it shows that whole frames decode with a correct check field and that back-to-back frames share one flag. It also shows that underruns and abort requests end the frame, that abort requests in idle are ignored, and that idle fill follows `idle_flags`.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  localparam logic [BYTE_W-1:0] FLAG_OCTET    = 8'h7E;
  localparam logic [FCS_W-1:0]  CRC_PRESET    = 16'hFFFF;
  localparam logic [FCS_W-1:0]  CRC_POLY_REFL = 16'h8408;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_t;

  // One LSB-first CRC step for a single serial bit.
  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c,
                                                input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
  endfunction

endpackage

// File: rtl/sdlc_crc16.sv
module sdlc_crc16
  import sdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_init,
  input  logic             crc_feed,
  input  logic             crc_din,
  output logic [FCS_W-1:0] crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= CRC_PRESET;
    else if (crc_init) crc_q <= CRC_PRESET;
    else if (crc_feed) crc_q <= crc_step(crc_q, crc_din);
  end

endmodule

// File: rtl/sdlc_zero_stuffer.sv
module sdlc_zero_stuffer #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic payload_bit,
  input  logic line_bit,
  output logic stuff_now
);

  localparam int RW = $clog2(STUFF_RUN + 1);

  logic [RW-1:0] ones_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ones_q <= '0;
    else if (bit_en) ones_q <= (payload_bit && line_bit) ? ones_q + RW'(1) : '0;
  end

  assign stuff_now = (ones_q == RW'(STUFF_RUN));

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RW'(STUFF_RUN));

endmodule

// File: rtl/sdlc_tx_seq.sv
module sdlc_tx_seq
  import sdlc_tx_pkg::*;
#(
  parameter int ABORT_ONES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              idle_flags,
  input  logic              abort_req,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              stuff_now,
  input  logic [FCS_W-1:0]  crc_q,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              line_nxt,
  output logic              payload_bit,
  output logic              crc_init,
  output logic              crc_feed
);

  localparam int CW = (ABORT_ONES > 16) ? $clog2(ABORT_ONES) : 4;
  localparam logic [CW-1:0] C_OCT_LAST = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] C_FCS_LAST = CW'(FCS_W - 1);
  localparam logic [CW-1:0] C_AB_LAST  = CW'(ABORT_ONES - 1);

  tx_state_t        st_q, st_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [FCS_W-1:0] sreg_q, sreg_n;
  logic             last_q, last_n;
  logic             accept;

  always_comb begin
    st_n        = st_q;
    cnt_n       = cnt_q;
    sreg_n      = sreg_q;
    last_n      = last_q;
    line_nxt    = tx_bit;
    payload_bit = 1'b0;
    crc_init    = 1'b0;
    crc_feed    = 1'b0;
    in_ready    = 1'b0;
    accept      = 1'b0;
    if (bit_en) begin
      unique case (st_q)
        ST_IDLE: begin
          line_nxt = idle_flags ? FLAG_OCTET[cnt_q[2:0]] : 1'b1;
          if (cnt_q == C_OCT_LAST) begin
            cnt_n = '0;
            if (in_valid) st_n = ST_OPEN;
          end else cnt_n = cnt_q + CW'(1);
        end
        ST_OPEN: begin
          line_nxt = FLAG_OCTET[cnt_q[2:0]];
          crc_init = 1'b1;
          if (cnt_q == C_OCT_LAST) begin
            cnt_n = '0;
            st_n  = ST_DATA;
          end else cnt_n = cnt_q + CW'(1);
        end
        ST_DATA, ST_FCS: begin
          if (abort_req) begin
            st_n     = ST_ABORT;
            cnt_n    = CW'(1);
            line_nxt = 1'b1;
          end else if (stuff_now) begin
            line_nxt    = 1'b0;
            payload_bit = 1'b1;
          end else if (st_q == ST_DATA && cnt_q == '0) begin
            in_ready = 1'b1;
            if (in_valid) begin
              accept      = 1'b1;
              line_nxt    = in_data[0];
              sreg_n      = {{(FCS_W-BYTE_W){1'b0}}, in_data} >> 1;
              last_n      = in_last;
              cnt_n       = CW'(1);
              payload_bit = 1'b1;
              crc_feed    = 1'b1;
            end else begin
              st_n     = ST_ABORT;
              cnt_n    = CW'(1);
              line_nxt = 1'b1;
            end
          end else if (st_q == ST_DATA) begin
            line_nxt    = sreg_q[0];
            sreg_n      = sreg_q >> 1;
            payload_bit = 1'b1;
            crc_feed    = 1'b1;
            if (cnt_q == C_OCT_LAST) begin
              cnt_n = '0;
              if (last_q) st_n = ST_FCS;
            end else cnt_n = cnt_q + CW'(1);
          end else begin
            payload_bit = 1'b1;
            if (cnt_q == '0) begin
              line_nxt = ~crc_q[0];
              sreg_n   = (~crc_q) >> 1;
            end else begin
              line_nxt = sreg_q[0];
              sreg_n   = sreg_q >> 1;
            end
            if (cnt_q == C_FCS_LAST) begin
              cnt_n = '0;
              st_n  = ST_CLOSE;
            end else cnt_n = cnt_q + CW'(1);
          end
        end
        ST_CLOSE: begin
          crc_init = 1'b1;
          if (stuff_now) begin
            line_nxt    = 1'b0;
            payload_bit = 1'b1;
          end else begin
            line_nxt = FLAG_OCTET[cnt_q[2:0]];
            if (cnt_q == C_OCT_LAST) begin
              cnt_n = '0;
              st_n  = in_valid ? ST_DATA : ST_IDLE;
            end else cnt_n = cnt_q + CW'(1);
          end
        end
        ST_ABORT: begin
          line_nxt = 1'b1;
          if (cnt_q == C_AB_LAST) begin
            cnt_n = '0;
            st_n  = ST_IDLE;
          end else cnt_n = cnt_q + CW'(1);
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sreg_q <= '0;
      last_q <= 1'b0;
      tx_bit <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sreg_q <= sreg_n;
      last_q <= last_n;
      tx_bit <= line_nxt;
    end
  end

  assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now && !abort_req) |=> !tx_bit);

  assert_abort_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st_q == ST_ABORT) |=> tx_bit);

  assert_lsb_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_bit == $past(in_data[0])));

  assert_open_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st_q == ST_OPEN && cnt_q == '0) |=> !tx_bit);

endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx
  import sdlc_tx_pkg::*;
#(
  parameter int ABORT_ONES = 8,
  parameter int STUFF_RUN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       idle_flags,
  input  logic       abort_req,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_bit
);

  logic             stuff_now;
  logic             line_nxt;
  logic             payload_bit;
  logic             crc_init;
  logic             crc_feed;
  logic [FCS_W-1:0] crc_q;

  sdlc_tx_seq #(.ABORT_ONES(ABORT_ONES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .idle_flags (idle_flags),
    .abort_req  (abort_req),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .stuff_now  (stuff_now),
    .crc_q      (crc_q),
    .in_ready   (in_ready),
    .tx_bit     (tx_bit),
    .line_nxt   (line_nxt),
    .payload_bit(payload_bit),
    .crc_init   (crc_init),
    .crc_feed   (crc_feed)
  );

  sdlc_zero_stuffer #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .payload_bit(payload_bit),
    .line_bit   (line_nxt),
    .stuff_now  (stuff_now)
  );

  sdlc_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .crc_init(crc_init),
    .crc_feed(crc_feed),
    .crc_din (line_nxt),
    .crc_q   (crc_q)
  );

  assert_stuff_skips_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now && !crc_init) |=> $stable(crc_q));

endmodule

// File: tb/sdlc_frame_tx_tb.sv
module sdlc_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       idle_flags = 1'b1;
  logic       abort_req = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       tx_bit;

  always #5 clk = ~clk;

  sdlc_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_flags(idle_flags),
    .abort_req(abort_req), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit strobe: one clock in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  end

  // ---------------- line receiver model ----------------
  logic       bit_en_d = 1'b0;
  int         ones = 0, nbits = 0, plen = 0;
  bit         in_fr = 1'b0;
  logic       rxbits [0:1023];
  logic [7:0] rx_mem [0:15][0:63];
  int         rx_len [0:15];
  int         rx_gap [0:15];
  int         frames = 0, aborts = 0, badfr = 0, gap = 0, flags = 0, abort_run = 0;
  int         ready_glitch = 0, hs_count = 0;

  always @(posedge clk) bit_en_d <= bit_en;

  always @(negedge clk) begin
    if (rst_n && bit_en_d) begin
      if (tx_bit) begin
        ones++;
        if (ones == 7) begin
          if (in_fr && nbits > 5) aborts++;
          in_fr = 1'b0;
          nbits = 0;
        end else if (ones <= 5 && in_fr && nbits < 1024) begin
          rxbits[nbits] = 1'b1;
          nbits++;
        end
      end else begin
        if (ones >= 7) abort_run = ones;
        if (ones == 6) begin
          flags++;
          plen = nbits - 6;
          if (in_fr && plen > 0) begin
            if (plen % 8 != 0 || plen < 24) badfr++;
            else begin
              for (int k = 0; k < plen / 8; k++)
                for (int j = 0; j < 8; j++)
                  rx_mem[frames % 16][k][j] = rxbits[8 * k + j];
              rx_len[frames % 16] = plen / 8;
              rx_gap[frames % 16] = gap;
              gap = 0;
              frames++;
            end
          end else gap++;
          in_fr = 1'b1;
          nbits = 0;
        end else if (ones != 5 && ones < 7 && in_fr && nbits < 1024) begin
          rxbits[nbits] = 1'b0;
          nbits++;
        end
        ones = 0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && in_ready && !bit_en) ready_glitch++;
  end

  // ---------------- source ----------------
  logic [7:0] tx_buf [0:63];

  task automatic send_bytes(input int n, input bit with_last);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = tx_buf[i];
      in_last  = with_last && (i == n - 1);
      do begin
        @(negedge clk);
        #1;
      end while (!in_ready);
      @(posedge clk);
      #1;
      hs_count++;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
  endtask

  // Residual: CRC over payload plus check, written as a byte-wise walk.
  function automatic logic [15:0] residual(input int idx);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < rx_len[idx]; k++) begin
      logic [7:0] by = rx_mem[idx][k];
      for (int j = 0; j < 8; j++) begin
        if ((c[0] ^ by[j]) == 1'b1) c = {1'b0, c[15:1]} ^ 16'h8408;
        else c = {1'b0, c[15:1]};
      end
    end
    return c;
  endfunction

  task automatic check_frame(input int idx, input int n, input string req);
    int bad = 0;
    check(rx_len[idx] == n + 2, req, rx_len[idx], n + 2);
    for (int k = 0; k < n; k++) if (rx_mem[idx][k] != tx_buf[k]) bad++;
    check(bad == 0, req, bad, 0);
    check(residual(idx) == 16'hF0B8, "R5 residual", residual(idx), 16'hF0B8);
  endtask

  localparam int TV_N = 6;
  localparam int TV_LEN [TV_N] = '{1, 2, 3, 4, 8, 5};
  localparam logic [63:0] TV_DATA [TV_N] = '{
    64'h00,
    64'hFFFF,
    64'h7E7E7E,
    64'h1FF88001,
    64'hA55A_3CC3_F00F_FE01,
    64'h00_7F_FE_FC_3F
  };

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int base_f, base_a, base_hs, base_flags;

  initial begin
    repeat (3) @(negedge clk);
    check(tx_bit == 1'b1, "R1 tx_bit in reset", tx_bit, 1);
    check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit == 1'b1 && in_ready == 1'b0, "R1 after reset", {tx_bit, in_ready}, 2);
    repeat (100) @(posedge clk);
    check(flags >= 2, "R2 idle flags seen", flags, 2);
    check(aborts == 0, "R2 no abort in flag idle", aborts, 0);

    // stimulus table
    for (int v = 0; v < TV_N; v++) begin
      base_f = frames;
      for (int k = 0; k < TV_LEN[v]; k++) tx_buf[k] = TV_DATA[v][8 * k +: 8];
      send_bytes(TV_LEN[v], 1'b1);
      wait_frames(base_f + 1);
      check(frames == base_f + 1, "R3 frame decoded", frames, base_f + 1);
      check_frame(base_f % 16, TV_LEN[v], "R4 R6 payload bytes");
      check(rx_gap[base_f % 16] > 0, "R7 separated by idle flags", rx_gap[base_f % 16], 1);
    end
    check(badfr == 0, "R4 no misaligned frames", badfr, 0);

    // known check value
    base_f = frames;
    for (int k = 0; k < 9; k++) tx_buf[k] = 8'h31 + 8'(k);
    send_bytes(9, 1'b1);
    wait_frames(base_f + 1);
    check(rx_mem[base_f % 16][9] == 8'h6E, "R5 check low byte", rx_mem[base_f % 16][9], 8'h6E);
    check(rx_mem[base_f % 16][10] == 8'h90, "R5 check high byte", rx_mem[base_f % 16][10], 8'h90);

    // back-to-back frames share one flag
    base_f = frames;
    tx_buf[0] = 8'hC3; tx_buf[1] = 8'h1F;
    send_bytes(2, 1'b1);
    tx_buf[0] = 8'hF8; tx_buf[1] = 8'h55; tx_buf[2] = 8'hFF;
    send_bytes(3, 1'b1);
    wait_frames(base_f + 2);
    check(frames == base_f + 2, "R7 two frames", frames, base_f + 2);
    check(rx_gap[(base_f + 1) % 16] == 0, "R7 shared flag", rx_gap[(base_f + 1) % 16], 0);
    check_frame((base_f + 1) % 16, 3, "R7 second frame bytes");

    // abort request in idle is ignored
    base_a = aborts; base_flags = flags;
    repeat (8) @(posedge clk);
    abort_req = 1'b1;
    repeat (60) @(posedge clk);
    abort_req = 1'b0;
    repeat (40) @(posedge clk);
    check(aborts == base_a, "R8 idle abort ignored", aborts, base_a);
    check(flags > base_flags, "R8 idle flags continue", flags, base_flags + 1);

    // abort request mid-frame
    base_a = aborts; base_f = frames; base_hs = hs_count;
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56;
    send_bytes(3, 1'b0);
    in_valid = 1'b1; in_data = 8'h77;
    abort_req = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    abort_req = 1'b0;
    in_valid = 1'b0;
    repeat (200) @(posedge clk);
    check(hs_count == base_hs + 3, "R8 no byte after abort", hs_count, base_hs + 3);
    check(aborts == base_a + 1, "R8 abort seen", aborts, base_a + 1);
    check(abort_run >= 8, "R8 abort run length", abort_run, 8);
    check(frames == base_f, "R8 no frame delivered", frames, base_f);

    // underrun
    base_a = aborts; base_f = frames;
    tx_buf[0] = 8'h55;
    send_bytes(1, 1'b0);
    repeat (200) @(posedge clk);
    check(aborts == base_a + 1, "R9 underrun abort", aborts, base_a + 1);
    check(frames == base_f, "R9 no frame delivered", frames, base_f);

    // ones idle
    idle_flags = 1'b0;
    repeat (160) @(posedge clk);
    check(ones >= 20, "R2 ones idle", ones, 20);
    base_f = frames;
    tx_buf[0] = 8'h81; tx_buf[1] = 8'h7E;
    send_bytes(2, 1'b1);
    wait_frames(base_f + 1);
    check(frames == base_f + 1, "R3 frame after ones idle", frames, base_f + 1);
    check_frame(base_f % 16, 2, "R3 bytes after ones idle");

    check(ready_glitch == 0, "R10 ready only on strobe", ready_glitch, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule